// File: doc/BRIEF.md
# Translation Buffer Maintenance Register Front End

This block is the set of special registers that software uses to inspect and maintain the entries of a translation buffer. It holds three state registers: an entry selector, the current address-space identifier and a zone protection word. It also contains the per-entry tag, data and owner-identifier storage, which software reaches through two entry windows. The tag window reaches the tag array and the data window reaches the data array, both at the entry named by the selector.

A third kind of register, the probe register, sends the page-number part of the written value to an external translator over a single-cycle lookup port. The result is written back into the selector. When an entry tag or the protection state is rewritten, the block raises a one-cycle flush pulse so that cached translations can be dropped.

Two configuration inputs gate all accesses. The first is a level for the translation unit; the second is a software access level. Register numbers are fixed: 0 data window, 1 tag window, 2 selector, 3 identifier, 4 zone word, 5 probe. At most one of read and write is expected per cycle. If both are raised, the write takes effect and the side effect of the read is dropped.

Top module: `tlb_sreg_if`

## Requirements
- R1: After a synchronous active-low reset, the selector, identifier and zone word read as zero. Every entry's tag, data and owner identifier is zero, and `flush_entry` and `flush_all` are low.
- R2: When `cfg_mmu` is below 2 or `cfg_access` is 0, every write is ignored, every read returns zero in the same cycle, and `lkp_req` stays low.
- R3: Register 0 reads and writes the data array and register 1 reads and writes the tag array, at the entry given by bits [7:0] of the selector. An entry number at or above ENTRIES makes window writes have no effect and window reads return zero.
- R4: A permitted read of register 1 loads the identifier register, on the next clock edge, with that entry's owner identifier zero-extended.
- R5: A write of register 1 stores bits [7:0] of the current identifier as the entry's owner identifier. In the next cycle it pulses `flush_entry` high for one cycle, with `flush_idx` equal to the entry number.
- R6: A permitted write of register 5 raises `lkp_req` in the same cycle, with `lkp_epn` equal to bits [31:10] of the written value. On a hit the selector becomes the zero-extended `lkp_idx` from the next cycle. On a miss, bit 31 of the selector is set and its other bits are kept.
- R7: Writes to registers 3, 4 and 5 take effect only when `cfg_access` is 2 or 3. Otherwise they change nothing and start no lookup. Writes to registers 0, 1 and 2 need only the global enable of R2.
- R8: Reads of registers 0, 1, 3 and 4 return zero unless bit 0 of `cfg_access` is set. Reads of register 2 need only the global enable.
- R9: A permitted write to register 3 or 4 whose value differs from the stored value pulses `flush_all` high for one cycle in the next cycle. Writing the same value gives no pulse.
- R10: Reads of register 5 and of register numbers 6 and 7 return zero. Writes to numbers 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mmu | input | 2 | Translation unit level; below 2 disables the block |
| cfg_access | input | 2 | Software access level |
| reg_sel | input | 3 | Register number |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | DW | Write value |
| rdata | output | DW | Read value, combinational |
| lkp_req | output | 1 | Lookup request to the translator |
| lkp_epn | output | DW-10 | Page number to look up |
| lkp_hit | input | 1 | Translator hit, same cycle |
| lkp_idx | input | 8 | Matching entry number on a hit |
| flush_entry | output | 1 | One-cycle pulse: drop translations of one entry |
| flush_idx | output | 8 | Entry number for `flush_entry` |
| flush_all | output | 1 | One-cycle pulse: drop all cached translations |

## Verification
The window path is driven with distinct values at several entries. Reading back an earlier entry after a later one was written shows that the selector and not a stale address picks the entry. An out-of-range selector shows that a truncated address does not alias a real entry. The probe is driven once with a hit and once with a miss from a preset selector: the hit shows the overwrite, the miss shows that only the top bit is added. The access levels are swept (1, 2, 0, and a low unit level), with reads made before and after each denied write. This separates the write gate from the read gate. Zone and identifier writes are repeated with equal values to separate a change from a plain write.

// File: rtl/tlb_sreg_pkg.sv
// Shared register numbering and field positions for the translation buffer
// maintenance register front end. Assumes a 3-bit register number.
package tlb_sreg_pkg;
    typedef enum logic [2:0] {
        SEL_DATA  = 3'd0,
        SEL_TAG   = 3'd1,
        SEL_INDEX = 3'd2,
        SEL_PID   = 3'd3,
        SEL_ZONE  = 3'd4,
        SEL_PROBE = 3'd5
    } sreg_sel_e;

    localparam int EPN_LSB = 10;  // smallest page is 1 KiB
    localparam int IDW     = 8;   // entry number / owner id width
endpackage

// File: rtl/tlb_sreg_gate.sv
// Access permission decode. Combinational; it derives the global enable and
// the per-register read and write permissions from the two configuration
// levels. Assumes the register numbering of tlb_sreg_pkg.
module tlb_sreg_gate
    import tlb_sreg_pkg::*;
(
    input  logic [1:0] cfg_mmu,
    input  logic [1:0] cfg_access,
    input  logic [2:0] reg_sel,
    output logic       on,
    output logic       wr_ok,
    output logic       rd_ok
);
    logic priv_wr;

    // global enable: translation unit present and any access level
    assign on      = (cfg_mmu >= 2'd2) && (cfg_access != 2'd0);
    assign priv_wr = (cfg_access >= 2'd2);

    // per-register write permission
    always_comb begin
        wr_ok = 1'b0;
        if (on) begin
            case (reg_sel)
                SEL_DATA, SEL_TAG, SEL_INDEX: wr_ok = 1'b1;
                SEL_PID, SEL_ZONE, SEL_PROBE: wr_ok = priv_wr;
                default:                      wr_ok = 1'b0;
            endcase
        end
    end

    // per-register read permission
    always_comb begin
        rd_ok = 1'b0;
        if (on) begin
            case (reg_sel)
                SEL_DATA, SEL_TAG, SEL_PID, SEL_ZONE: rd_ok = cfg_access[0];
                SEL_INDEX:                            rd_ok = 1'b1;
                default:                              rd_ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/tlb_sreg_ram.sv
// Per-entry tag, data and owner identifier storage. One write port per
// array sharing an address, asynchronous read. Assumes ENTRIES >= 2 and
// that the caller has range-checked the address.
module tlb_sreg_ram #(
    parameter int ENTRIES = 16,
    parameter int DW      = 32,
    parameter int IDW     = 8,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  addr,
    input  logic           we_tag,
    input  logic           we_data,
    input  logic [DW-1:0]  wval,
    input  logic [IDW-1:0] wtid,
    output logic [DW-1:0]  rtag,
    output logic [DW-1:0]  rdat,
    output logic [IDW-1:0] rtid
);
    logic [DW-1:0]  tag_mem [ENTRIES];
    logic [DW-1:0]  dat_mem [ENTRIES];
    logic [IDW-1:0] tid_mem [ENTRIES];

    // one storage slot per entry, cleared by reset
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_mem[e] <= '0;
                dat_mem[e] <= '0;
                tid_mem[e] <= '0;
            end else if (addr == AW'(e)) begin
                if (we_tag) begin
                    tag_mem[e] <= wval;
                    tid_mem[e] <= wtid;
                end
                if (we_data) dat_mem[e] <= wval;
            end
        end
    end

    assign rtag = tag_mem[addr];
    assign rdat = dat_mem[addr];
    assign rtid = tid_mem[addr];
endmodule

// File: rtl/tlb_sreg_if.sv
// Translation buffer maintenance register front end. Holds the selector,
// identifier and zone registers, routes window accesses to entry storage,
// launches probe lookups and raises flush pulses. Assumes DW >= 16,
// ENTRIES <= 256, and a translator that answers a lookup in the same cycle.
module tlb_sreg_if
    import tlb_sreg_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int DW      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mmu,
    input  logic [1:0]         cfg_access,
    input  logic [2:0]         reg_sel,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic               lkp_req,
    output logic [DW-EPN_LSB-1:0] lkp_epn,
    input  logic               lkp_hit,
    input  logic [IDW-1:0]     lkp_idx,
    output logic               flush_entry,
    output logic [IDW-1:0]     flush_idx,
    output logic               flush_all
);
    localparam int AW = $clog2(ENTRIES);
    localparam logic [IDW:0] ENT_LIM = (IDW+1)'(ENTRIES);

    logic [DW-1:0]  idx_q, pid_q, zpr_q;
    logic           on, wr_ok, rd_ok, wr_go, rd_go;
    logic [IDW-1:0] ent_num;
    logic           in_range, we_tag, we_dat;
    logic [DW-1:0]  r_tag, r_dat;
    logic [IDW-1:0] r_tid;
    logic           chg;

    tlb_sreg_gate u_gate (
        .cfg_mmu   (cfg_mmu),
        .cfg_access(cfg_access),
        .reg_sel   (reg_sel),
        .on        (on),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok)
    );

    assign wr_go    = wr_en && wr_ok;
    assign rd_go    = rd_en && rd_ok;
    assign ent_num  = idx_q[IDW-1:0];
    assign in_range = ({1'b0, ent_num} < ENT_LIM);
    assign we_tag   = wr_go && (reg_sel == SEL_TAG)  && in_range;
    assign we_dat   = wr_go && (reg_sel == SEL_DATA) && in_range;

    tlb_sreg_ram #(.ENTRIES(ENTRIES), .DW(DW), .IDW(IDW)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (ent_num[AW-1:0]),
        .we_tag (we_tag),
        .we_data(we_dat),
        .wval   (wdata),
        .wtid   (pid_q[IDW-1:0]),
        .rtag   (r_tag),
        .rdat   (r_dat),
        .rtid   (r_tid)
    );

    // probe lookup request to the translator
    assign lkp_req = wr_go && (reg_sel == SEL_PROBE);
    assign lkp_epn = wdata[DW-1:EPN_LSB];

    // protection state change detect
    assign chg = wr_go && (((reg_sel == SEL_PID)  && (wdata != pid_q)) ||
                           ((reg_sel == SEL_ZONE) && (wdata != zpr_q)));

    // state registers and their access side effects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            pid_q <= '0;
            zpr_q <= '0;
        end else if (wr_go) begin
            case (reg_sel)
                SEL_INDEX: idx_q <= wdata;
                SEL_PID:   pid_q <= wdata;
                SEL_ZONE:  zpr_q <= wdata;
                SEL_PROBE: idx_q <= lkp_hit ? DW'(lkp_idx)
                                            : (idx_q | {1'b1, {(DW-1){1'b0}}});
                default:   ;
            endcase
        end else if (rd_go && (reg_sel == SEL_TAG) && in_range) begin
            pid_q <= DW'(r_tid);
        end
    end

    // flush pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_entry <= 1'b0;
            flush_idx   <= '0;
            flush_all   <= 1'b0;
        end else begin
            flush_entry <= we_tag;
            if (we_tag) flush_idx <= ent_num;
            flush_all   <= chg;
        end
    end

    // read data mux
    always_comb begin
        rdata = '0;
        if (rd_go) begin
            case (reg_sel)
                SEL_DATA:  rdata = in_range ? r_dat : '0;
                SEL_TAG:   rdata = in_range ? r_tag : '0;
                SEL_INDEX: rdata = idx_q;
                SEL_PID:   rdata = pid_q;
                SEL_ZONE:  rdata = zpr_q;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tlb_sreg_chk.sv
// Property checker for tlb_sreg_if, attached with bind below. Observes
// ports and the selector register only.
module tlb_sreg_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cfg_mmu,
    input logic [1:0]    cfg_access,
    input logic [2:0]    reg_sel,
    input logic          wr_en,
    input logic          rd_en,
    input logic [DW-1:0] rdata,
    input logic          lkp_req,
    input logic          lkp_hit,
    input logic [7:0]    lkp_idx,
    input logic          flush_entry,
    input logic          flush_all,
    input logic [DW-1:0] idx_q
);
    logic started;

    // marks that one clock with reset released has passed
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    logic off;
    assign off = (cfg_mmu < 2'd2) || (cfg_access == 2'd0);

    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        off |-> (rdata == '0 && !lkp_req));

    assert_probe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_req |-> (wr_en && reg_sel == 3'd5 && cfg_access >= 2'd2));

    assert_miss_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_req && !lkp_hit) |=> idx_q[DW-1]);

    assert_hit_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_req && lkp_hit) |=> (idx_q == DW'($past(lkp_idx))));

    assert_denied_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !cfg_access[0] &&
         (reg_sel == 3'd0 || reg_sel == 3'd1 || reg_sel == 3'd3 || reg_sel == 3'd4))
        |-> (rdata == '0));

    assert_flush_all_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (started && flush_all) |-> $past(wr_en && (reg_sel == 3'd3 || reg_sel == 3'd4)));

    assert_flush_entry_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (started && flush_entry) |-> $past(wr_en && reg_sel == 3'd1));
endmodule

bind tlb_sreg_if tlb_sreg_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mmu    (cfg_mmu),
    .cfg_access (cfg_access),
    .reg_sel    (reg_sel),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rdata      (rdata),
    .lkp_req    (lkp_req),
    .lkp_hit    (lkp_hit),
    .lkp_idx    (lkp_idx),
    .flush_entry(flush_entry),
    .flush_all  (flush_all),
    .idx_q      (idx_q)
);

// File: tb/sim_tlb_sreg_if.sv
// Directed bench for tlb_sreg_if: one task per scenario, each self-checking.
module sim_tlb_sreg_if;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mmu = 2'd3;
    logic [1:0]    cfg_access = 2'd3;
    logic [2:0]    reg_sel = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          lkp_req;
    logic [21:0]   lkp_epn;
    logic          lkp_hit = 1'b0;
    logic [7:0]    lkp_idx = '0;
    logic          flush_entry;
    logic [7:0]    flush_idx;
    logic          flush_all;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tlb_sreg_if #(.ENTRIES(16), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mmu(cfg_mmu), .cfg_access(cfg_access),
        .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .lkp_req(lkp_req), .lkp_epn(lkp_epn),
        .lkp_hit(lkp_hit), .lkp_idx(lkp_idx), .flush_entry(flush_entry),
        .flush_idx(flush_idx), .flush_all(flush_all)
    );

    task automatic chk(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write one register; returns one step after the capturing edge
    task automatic wr(input logic [2:0] sel, input logic [DW-1:0] v);
        @(negedge clk);
        reg_sel = sel; wdata = v; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // read one register and compare in the same cycle
    task automatic rd(input logic [2:0] sel, input logic [DW-1:0] exp,
                      input string req);
        @(negedge clk);
        reg_sel = sel; rd_en = 1'b1;
        #1 chk(req, rdata, exp);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        rd(3'd2, '0, "R1 selector");
        rd(3'd3, '0, "R1 identifier");
        rd(3'd4, '0, "R1 zone");
        rd(3'd0, '0, "R1 data entry0");
        rd(3'd1, '0, "R1 tag entry0");
        chk("R1 flush_entry", DW'(flush_entry), '0);
        chk("R1 flush_all", DW'(flush_all), '0);
    endtask

    task automatic t_windows();
        wr(3'd3, 32'h0000_005A);
        wr(3'd2, 32'd2);
        wr(3'd1, 32'hABCD_0040);
        chk("R5 flush_entry pulse", DW'(flush_entry), 1);
        chk("R5 flush_idx", DW'(flush_idx), 2);
        wr(3'd0, 32'h1234_5678);
        chk("R5 flush_entry one cycle", DW'(flush_entry), 0);
        wr(3'd2, 32'd3);
        wr(3'd0, 32'hCAFE_0003);
        wr(3'd2, 32'd2);
        rd(3'd0, 32'h1234_5678, "R3 data entry2");
        rd(3'd1, 32'hABCD_0040, "R3 tag entry2");
        wr(3'd2, 32'd3);
        rd(3'd0, 32'hCAFE_0003, "R3 data entry3");
    endtask

    task automatic t_owner();
        wr(3'd3, 32'h0000_0366);
        wr(3'd2, 32'd5);
        wr(3'd1, 32'h5555_0040);
        wr(3'd3, 32'h0000_0011);
        rd(3'd1, 32'h5555_0040, "R4 tag entry5");
        rd(3'd3, 32'h0000_0066, "R5 owner low byte to R4 identifier");
        wr(3'd2, 32'd2);
        rd(3'd1, 32'hABCD_0040, "R4 tag entry2");
        rd(3'd3, 32'h0000_005A, "R4 identifier from entry2");
    endtask

    task automatic t_range();
        wr(3'd2, 32'd20);
        wr(3'd0, 32'hDEAD_BEEF);
        wr(3'd1, 32'hDEAD_0040);
        chk("R3 no flush out of range", DW'(flush_entry), 0);
        rd(3'd0, '0, "R3 data out of range");
        rd(3'd1, '0, "R3 tag out of range");
        wr(3'd2, 32'd4);
        rd(3'd0, '0, "R3 entry4 not aliased");
    endtask

    task automatic t_probe();
        lkp_hit = 1'b1; lkp_idx = 8'd7;
        @(negedge clk);
        reg_sel = 3'd5; wdata = 32'hFFFF_FFFF; wr_en = 1'b1;
        #1 chk("R6 lkp_req", DW'(lkp_req), 1);
        chk("R6 lkp_epn", DW'(lkp_epn), 32'h003F_FFFF);
        @(posedge clk); #1; wr_en = 1'b0;
        rd(3'd2, 32'd7, "R6 hit index");
        wr(3'd2, 32'h0000_0009);
        lkp_hit = 1'b0;
        wr(3'd5, 32'h0001_2C00);
        rd(3'd2, 32'h8000_0009, "R6 miss flag");
    endtask

    task automatic t_access();
        wr(3'd3, 32'h0000_0042);
        wr(3'd4, 32'h0000_0F0F);
        cfg_access = 2'd1;
        wr(3'd3, 32'h0000_0099);
        rd(3'd3, 32'h0000_0042, "R7 identifier write ignored");
        wr(3'd4, 32'h0000_1111);
        chk("R7 no flush on ignored zone", DW'(flush_all), 0);
        rd(3'd4, 32'h0000_0F0F, "R7 zone write ignored");
        wr(3'd2, 32'd9);
        @(negedge clk);
        reg_sel = 3'd5; wdata = 32'h0000_0400; wr_en = 1'b1;
        #1 chk("R7 no lookup at level 1", DW'(lkp_req), 0);
        @(posedge clk); #1; wr_en = 1'b0;
        rd(3'd2, 32'd9, "R7 selector kept after ignored probe");
        wr(3'd0, 32'h0BAD_F00D);
        rd(3'd0, 32'h0BAD_F00D, "R7 window write at level 1");
        cfg_access = 2'd2;
        rd(3'd3, '0, "R8 identifier read denied");
        rd(3'd0, '0, "R8 data read denied");
        rd(3'd2, 32'd9, "R8 selector read allowed");
        cfg_access = 2'd3;
    endtask

    task automatic t_gate();
        cfg_mmu = 2'd1;
        wr(3'd2, 32'd1);
        rd(3'd2, '0, "R2 read zero, low unit level");
        cfg_mmu = 2'd3; cfg_access = 2'd0;
        wr(3'd2, 32'd1);
        rd(3'd2, '0, "R2 read zero, level 0");
        cfg_access = 2'd3;
        rd(3'd2, 32'd9, "R2 selector unchanged");
    endtask

    task automatic t_flush();
        wr(3'd4, 32'h0000_00F0);
        chk("R9 zone change pulse", DW'(flush_all), 1);
        wr(3'd4, 32'h0000_00F0);
        chk("R9 zone same value", DW'(flush_all), 0);
        wr(3'd3, 32'h0000_0001);
        chk("R9 identifier change pulse", DW'(flush_all), 1);
        @(posedge clk); #1;
        chk("R9 pulse one cycle", DW'(flush_all), 0);
        wr(3'd3, 32'h0000_0001);
        chk("R9 identifier same value", DW'(flush_all), 0);
    endtask

    task automatic t_map();
        rd(3'd5, '0, "R10 probe read zero");
        wr(3'd6, 32'h1234_5678);
        wr(3'd7, 32'h8765_4321);
        rd(3'd6, '0, "R10 unused read zero");
        rd(3'd2, 32'd9, "R10 selector untouched");
        rd(3'd3, 32'h0000_0001, "R10 identifier untouched");
        rd(3'd4, 32'h0000_00F0, "R10 zone untouched");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_windows();
        t_owner();
        t_range();
        t_probe();
        t_access();
        t_gate();
        t_flush();
        t_map();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule